// File: doc/BRIEF.md
# Local Interrupt Timer with Power-of-Two Divider

This block is a per-processor countdown timer that raises an interrupt request when its count runs out. Software programs three things through a single write port: an initial count, a divide configuration that picks a power-of-two prescale from 1 to 128, and a timer entry word holding an 8-bit interrupt vector, a mask bit and a periodic-mode bit. Writing a nonzero initial count loads the counter and starts a new period. The counter then steps down once per divided tick. One full period lasts initial count plus one divided ticks.

At the end of each period the block emits a single-cycle pulse carrying the vector. In one-shot mode it then stops with the count reading zero. In periodic mode it reloads and runs again, so expiries fall at whole multiples of the period after the load. While the mask bit is set the counter keeps running but no pulse is emitted. An initial count of zero stops the timer in either mode. The current count is always readable.

Control is a three-state machine. `ST_IDLE` means stopped. `ST_RUN` means counting. `ST_DONE` means a one-shot has expired. Its transitions are:
- load-nonzero: any state to `ST_RUN`.
- load-zero: any state to `ST_IDLE`.
- reload: `ST_RUN` to `ST_RUN`, when a periodic period expires.
- expire-once: `ST_RUN` to `ST_DONE`, when a one-shot period expires.

A tick prescaler and a register slice surround the machine.

Top module: `loc_irq_timer`

## Requirements
- R1: After reset the count reads 0 and no pulse is emitted. The timer entry is masked with vector 0 and one-shot mode. The divide is 1.
- R2: A write with `wr_sel`=1 sets the divide from data bits {3,1,0} read as a 3-bit code v. The divide is 2^((v+1) mod 8), so codes 0..6 give 2..128 and code 7 gives 1. The write also restarts the prescaler.
- R3: In one-shot mode, an initial count N>0 written at edge E produces exactly one pulse, at edge E+(N+1)·D. After n edges the count reads max(N−floor(n/D), 0).
- R4: In periodic mode with N>0, a pulse occurs at every edge E+k·(N+1)·D for k≥1. After n edges the count reads N − (floor(n/D) mod (N+1)).
- R5: Writing an initial count of 0 (`wr_sel`=0) stops the timer in either mode. The count then reads 0 and no pulse follows.
- R6: While the entry's mask bit (bit 16) is set, no pulse is emitted, but counting and reloading proceed unchanged.
- R7: Writing an initial count while the timer runs discards the old progress and restarts timing from that write edge with the new value.
- R8: Each pulse lasts one cycle. During the pulse, `irq_vector` carries the entry's bits 7:0. The entry's bit 17 selects periodic (1) or one-shot (0).
- R9: A write with `wr_sel`=3 has no effect on the count or on the pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the undivided time base |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 initial count, 1 divide, 2 timer entry, 3 unused |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Current count value |
| irq_pulse | output | 1 | One-cycle expiry pulse |
| irq_vector | output | 8 | Vector accompanying the pulse |

## Verification
The bench sweeps all eight divide codes against several small initial counts in both modes, including zero. At every cycle it compares the count and the pulse against closed-form arithmetic. A wrong divide decode would stretch or shrink every period. An off-by-one period of N·D instead of (N+1)·D would shift each pulse by one tick. A one-shot that reloads would pulse again. A zero count that was not treated as a stop would fire after one tick. The bench also checks that a masked timer keeps counting while staying silent, that a reload mid-period restarts from the write edge, and that an unused register select leaves timing untouched.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ltmr_state_e;

    localparam logic [1:0] SEL_INIT  = 2'd0;
    localparam logic [1:0] SEL_DIV   = 2'd1;
    localparam logic [1:0] SEL_ENTRY = 2'd2;

    localparam int ENTRY_MASK_BIT = 16;
    localparam int ENTRY_PER_BIT  = 17;

    // Divide code {d3,d1,d0}; shift = code + 1, wrapping in three bits.
    function automatic logic [2:0] div_to_shift(input logic [3:0] d);
        logic [2:0] code;
        code = {d[3], d[1], d[0]};
        return code + 3'd1;
    endfunction
endpackage

// File: rtl/ltmr_regs.sv
module ltmr_regs
    import ltmr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 32,
    parameter int VEC_W   = 8,
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               load,
    output logic [CNT_W-1:0]   load_val,
    output logic [CNT_W-1:0]   init_q,
    output logic               div_wr,
    output logic [SHIFT_W-1:0] shift_q,
    output logic [VEC_W-1:0]   vector_q,
    output logic               mask_q,
    output logic               periodic_q
);
    assign load     = wr_en && (wr_sel == SEL_INIT);
    assign div_wr   = wr_en && (wr_sel == SEL_DIV);
    assign load_val = wr_data[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q     <= '0;
            shift_q    <= '0;
            vector_q   <= '0;
            mask_q     <= 1'b1;
            periodic_q <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_INIT:  init_q <= load_val;
                SEL_DIV:   shift_q <= SHIFT_W'(div_to_shift(wr_data[3:0]));
                SEL_ENTRY: begin
                    vector_q   <= wr_data[VEC_W-1:0];
                    mask_q     <= wr_data[ENTRY_MASK_BIT];
                    periodic_q <= wr_data[ENTRY_PER_BIT];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ltmr_prescaler.sv
module ltmr_prescaler #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               run,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;
    logic             at_limit;

    assign limit    = PRE_W'((1 << shift) - 1);
    assign at_limit = (pre_q >= limit);
    assign tick     = run && !clear && at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear || !run) begin
            pre_q <= '0;
        end else if (at_limit) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_q == '0)) else $error("prescaler did not restart"); // R2
endmodule

// File: rtl/ltmr_core.sv
module ltmr_core
    import ltmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] init_q,
    input  logic             tick,
    input  logic             periodic,
    input  logic             mask,
    input  logic [VEC_W-1:0] vector,
    output logic             running,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq_pulse,
    output logic [VEC_W-1:0] irq_vector
);
    ltmr_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             expire;

    assign running = (state_q == ST_RUN);
    assign expire  = !load && running && tick && (cnt_q == '0);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (load) begin
            state_d = (load_val != '0) ? ST_RUN : ST_IDLE;
            cnt_d   = load_val;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_RUN: begin
                    if (tick) begin
                        if (cnt_q != '0) begin
                            cnt_d = cnt_q - 1'b1;
                        end else if (periodic) begin
                            cnt_d = init_q;
                        end else begin
                            state_d = ST_DONE;
                            cnt_d   = '0;
                        end
                    end
                end
                ST_DONE: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_pulse  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_pulse <= expire && !mask;
            if (expire) begin
                irq_vector <= vector;
            end
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse) else $error("pulse longer than a cycle"); // R8
    AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> (state_q == ST_IDLE && cnt_q == '0 && !irq_pulse))
        else $error("zero load did not stop"); // R5
    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && $past(state_q == ST_DONE)) |-> (!irq_pulse && cnt_q == '0))
        else $error("one-shot fired again"); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt_q <= init_q)) else $error("count above initial"); // R4
endmodule

// File: rtl/loc_irq_timer.sv
module loc_irq_timer #(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 32,
    parameter int VEC_W   = 8,
    parameter int SHIFT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cur_count,
    output logic              irq_pulse,
    output logic [VEC_W-1:0]  irq_vector
);
    logic               load, div_wr, mask_q, periodic_q, tick, running;
    logic [CNT_W-1:0]   load_val, init_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [VEC_W-1:0]   vector_q;

    ltmr_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .VEC_W(VEC_W), .SHIFT_W(SHIFT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .load(load), .load_val(load_val),
        .init_q(init_q), .div_wr(div_wr), .shift_q(shift_q),
        .vector_q(vector_q), .mask_q(mask_q), .periodic_q(periodic_q)
    );

    ltmr_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(load || div_wr),
        .run(running), .shift(shift_q), .tick(tick)
    );

    ltmr_core #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_core (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .init_q(init_q), .tick(tick), .periodic(periodic_q),
        .mask(mask_q), .vector(vector_q), .running(running),
        .cnt_q(cur_count), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );
endmodule

// File: tb/loc_irq_timer_tb.sv
module loc_irq_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] cur_count;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    loc_irq_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cur_count(cur_count), .irq_pulse(irq_pulse),
        .irq_vector(irq_vector)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic longint exp_count(longint init, bit per, longint div, longint n);
        longint t;
        t = n / div;
        if (init == 0) return 0;
        if (per) return init - (t % (init + 1));
        return (t >= init) ? 0 : init - t;
    endfunction

    function automatic bit exp_pulse(longint init, bit per, bit msk, longint div, longint n);
        longint p;
        p = (init + 1) * div;
        if (init == 0 || msk || n == 0) return 1'b0;
        if (n % p != 0) return 1'b0;
        return per || (n == p);
    endfunction

    // Loads init, then checks every cycle; optional junk write at cycle junk_at.
    task automatic run(input longint init, input bit per, input bit msk, input longint div,
                       input logic [7:0] vec, input int ncyc, input int junk_at, input string req);
        wr(2'd0, 32'(init));
        for (int n = 0; n <= ncyc; n++) begin
            bit ep;
            longint ec;
            ec = exp_count(init, per, div, n);
            ep = exp_pulse(init, per, msk, div, n);
            chk(cur_count == 32'(ec), req, cur_count, ec);
            chk(irq_pulse == ep, req, irq_pulse, ep);
            if (ep) chk(irq_vector == vec, "R8 vector", irq_vector, vec);
            if (n == junk_at) begin
                wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'h0;
            end
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    logic [31:0] entry;

    initial begin
        #(8 * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cur_count == 0, "R1 count", cur_count, 0);
        chk(irq_pulse == 1'b0, "R1 pulse", irq_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cur_count == 0, "R1 count idle", cur_count, 0);
        // R1: masked one-shot, divide 1 after reset
        run(2, 1'b0, 1'b1, 1, 8'h00, 8, -1, "R1 default");

        // R2 R3 R4 R5 R8: sweep all divide codes, counts, modes
        for (int code = 0; code < 8; code++) begin
            longint dv;
            logic [3:0] dd;
            dd = {code[2], 1'b0, code[1:0]};
            dv = longint'(1) << ((code + 1) % 8);
            for (int per = 0; per < 2; per++) begin
                for (int init = 0; init < 4; init++) begin
                    logic [7:0] vec;
                    vec = 8'(8'h20 + code * 8 + init);
                    wr(2'd1, {28'h0, dd});
                    entry = {14'h0, per[0], 1'b0, 8'h0, vec};
                    wr(2'd2, entry);
                    run(init, per[0], 1'b0, dv, vec,
                        int'(3 * (init + 1) * dv + 2), -1,
                        per != 0 ? "R4 periodic R2" : "R3 oneshot R2");
                end
            end
        end

        // R6: masked periodic keeps counting, no pulse
        wr(2'd1, 32'h0);                       // divide 2
        wr(2'd2, {14'h0, 1'b1, 1'b1, 8'h0, 8'h5A});
        run(3, 1'b1, 1'b1, 2, 8'h5A, 30, -1, "R6 mask periodic");
        // R6: unmask mid-run by reloading with unmasked entry
        wr(2'd2, {14'h0, 1'b1, 1'b0, 8'h0, 8'h5A});
        run(3, 1'b1, 1'b0, 2, 8'h5A, 30, -1, "R6 unmasked");

        // R7: reload mid-period restarts timing
        wr(2'd2, {14'h0, 1'b1, 1'b0, 8'h0, 8'h77});
        run(6, 1'b1, 1'b0, 2, 8'h77, 9, -1, "R7 before reload");
        run(2, 1'b1, 1'b0, 2, 8'h77, 20, -1, "R7 after reload");

        // R5: zero load stops a running timer
        run(0, 1'b1, 1'b0, 2, 8'h77, 20, -1, "R5 zero stop");

        // R9: unused select ignored mid-run
        wr(2'd2, {14'h0, 1'b0, 1'b0, 8'h0, 8'h33});
        run(4, 1'b0, 1'b0, 2, 8'h33, 16, 3, "R9 unused sel");
        wr(2'd2, {14'h0, 1'b1, 1'b0, 8'h0, 8'h34});
        run(2, 1'b1, 1'b0, 2, 8'h34, 20, 5, "R9 unused sel periodic");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule